// File: doc/BRIEF.md
# Time-of-Day Strobe Divider Chain

This block turns a fast reference strobe into a ladder of single-cycle timing strobes: 50 Hz, one per second, one per minute, one per hour and one per day. Every stage runs on the one system clock. A stage advances only in a cycle where its input strobe is high, so no stage derives a clock from another.

The first section is a prescaler of decimal digits that divides the 500 kHz reference strobe by 10,000 down to 50 Hz. A parameter can bypass it, so that the reference strobe itself serves as the 50 Hz strobe. Each later divider is a pair of stages, a low stage followed by a high stage. A stage with modulus M restarts as soon as its next value reaches the first code whose set bits cover all set bits of M, for example 0110 for a divide-by-6. It does not use a full equality compare.

The seconds, minutes and hours positions are brought out as low and high digit pairs. Each moduli pair is a parameter of the top, with the time-of-day values as defaults.

Top module: `tod_divider_chain`

## Requirements
- R1: While `rst_n` is low, every count output is 0. With `ref_tick` low, every strobe output is also low.
- R2: With `PRESCALE_EN`=1, `tick_50hz` is high exactly in the cycle of every 10^`PRESCALE_DIGITS`-th high `ref_tick` cycle after reset. The default is every 10,000th.
- R3: With `PRESCALE_EN`=0, `tick_50hz` equals `ref_tick` in the same cycle.
- R4: `tick_sec` is high in the cycle of the `tick_50hz` strobe that completes each group of `FRAC_LO`×`FRAC_HI` strobes. The default group is 5×10.
- R5: `tick_min` is high in the cycle of the `tick_sec` strobe that completes each group of `SEC_LO`×`SEC_HI` strobes. The default is 6×10. `sec_lo` counts `tick_sec` strobes modulo `SEC_LO`, and `sec_hi` counts the wraps of `sec_lo` modulo `SEC_HI`.
- R6: `tick_hour` is high in the cycle of the `tick_min` strobe that completes each group of `MIN_LO`×`MIN_HI` strobes. The default is 6×10. `min_lo` and `min_hi` count in the same way as the seconds pair.
- R7: `tick_day` is high in the cycle of the `tick_hour` strobe that completes each group of `HOUR_LO`×`HOUR_HI` strobes. The default is 6×4. `hour_lo` and `hour_hi` count in the same way as the seconds pair.
- R8: In a cycle where a stage's input strobe is low, its count does not change and it emits no strobe.
- R9: A stage of modulus M never shows a count of M or above. On an input strobe it goes from M-1 to 0, and it restarts on the code whose set bits cover those of M.
- R10: A count changes at the clock edge that ends its input strobe cycle. An output strobe is high only in the single cycle of the input strobe that wraps its stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference strobe, one cycle per 500 kHz period |
| tick_50hz | output | 1 | 50 Hz strobe |
| tick_sec | output | 1 | Once-per-second strobe |
| tick_min | output | 1 | Once-per-minute strobe |
| tick_hour | output | 1 | Once-per-hour strobe |
| tick_day | output | 1 | Once-per-day strobe |
| sec_lo | output | 4 | Seconds low-stage count |
| sec_hi | output | 4 | Seconds high-stage count |
| min_lo | output | 4 | Minutes low-stage count |
| min_hi | output | 4 | Minutes high-stage count |
| hour_lo | output | 4 | Hours low-stage count |
| hour_hi | output | 4 | Hours high-stage count |

## Verification
The main instance runs with the prescaler bypassed and small moduli: 2×3, 6×2, 3×2 and 6×4. These keep the divide-by-6 restart and the 6×4 day chain, so that two full days fit in a short run. The reference strobe is applied back-to-back and also with regular gaps. Back-to-back strobes expose any stage that counts on idle cycles or loses a carry when several stages wrap in one cycle. The gaps show that counts hold and strobes stay low when no strobe arrives. A second instance with default parameters receives the same stream to confirm the 10,000 prescale count. A reset in the middle of a run shows that every count and strobe returns to zero.

// File: rtl/tod_pkg.sv
package tod_pkg;

  // Bits needed to hold values 0..mod (the terminal code included).
  function automatic int unsigned cnt_width(input int unsigned mod);
    int unsigned w;
    w = 1;
    while ((1 << w) <= mod) w++;
    return w;
  endfunction

  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned DECADE    = 10;

endpackage

// File: rtl/tod_mod_stage.sv
module tod_mod_stage #(
  parameter int unsigned MOD = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  output logic       tick_o,
  output logic [3:0] cnt_o
);
  localparam int unsigned W = tod_pkg::cnt_width(MOD);
  localparam logic [W-1:0] TERM = W'(MOD);

  logic [W-1:0] cnt_q, cnt_d, inc;
  logic         hit_term;

  // next-state
  always_comb begin
    inc      = cnt_q + W'(1);
    hit_term = ((inc & TERM) == TERM);
    cnt_d    = cnt_q;
    if (en_i) cnt_d = hit_term ? '0 : inc;
  end

  assign tick_o = en_i & hit_term;
  assign cnt_o  = 4'(cnt_q);

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: count stays inside modulus
  a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < TERM);
  // R9: wrap lands on zero
  a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
  // R8: idle cycles hold the count
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));
  // R10: output strobe lasts one cycle
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/tod_div_pair.sv
module tod_div_pair #(
  parameter int unsigned LO_MOD = 6,
  parameter int unsigned HI_MOD = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  output logic       tick_o,
  output logic [3:0] lo_o,
  output logic [3:0] hi_o
);
  logic lo_wrap;

  tod_mod_stage #(.MOD(LO_MOD)) u_lo (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_o(lo_wrap), .cnt_o(lo_o)
  );

  tod_mod_stage #(.MOD(HI_MOD)) u_hi (
    .clk(clk), .rst_n(rst_n), .en_i(lo_wrap), .tick_o(tick_o), .cnt_o(hi_o)
  );

  // R10: high stage only wraps on a strobe from the low stage
  a_r10_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> lo_wrap);

endmodule

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int unsigned DIGITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned DW = tod_pkg::DIGIT_W;

  logic [DIGITS:0] carry;
  assign carry[0] = en_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [DW-1:0] dig_q, dig_d, inc;
    logic          term;

    always_comb begin
      inc   = dig_q + DW'(1);
      term  = inc[3] & inc[1];   // 1010 restart detect
      dig_d = dig_q;
      if (carry[g]) dig_d = term ? '0 : inc;
    end

    assign carry[g+1] = carry[g] & term;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dig_q <= '0;
      else        dig_q <= dig_d;
    end

    // R2: each prescale digit stays decimal
    a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
      dig_q < DW'(tod_pkg::DECADE));
  end

  assign tick_o = carry[DIGITS];

endmodule

// File: rtl/tod_divider_chain.sv
module tod_divider_chain #(
  parameter bit          PRESCALE_EN     = 1'b1,
  parameter int unsigned PRESCALE_DIGITS = 4,
  parameter int unsigned FRAC_LO         = 5,
  parameter int unsigned FRAC_HI         = 10,
  parameter int unsigned SEC_LO          = 6,
  parameter int unsigned SEC_HI          = 10,
  parameter int unsigned MIN_LO          = 6,
  parameter int unsigned MIN_HI          = 10,
  parameter int unsigned HOUR_LO         = 6,
  parameter int unsigned HOUR_HI         = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  output logic       tick_50hz,
  output logic       tick_sec,
  output logic       tick_min,
  output logic       tick_hour,
  output logic       tick_day,
  output logic [3:0] sec_lo,
  output logic [3:0] sec_hi,
  output logic [3:0] min_lo,
  output logic [3:0] min_hi,
  output logic [3:0] hour_lo,
  output logic [3:0] hour_hi
);
  logic [3:0] frac_lo, frac_hi;
  logic       frac_unused;

  if (PRESCALE_EN) begin : g_pre
    tod_prescaler #(.DIGITS(PRESCALE_DIGITS)) u_pre (
      .clk(clk), .rst_n(rst_n), .en_i(ref_tick), .tick_o(tick_50hz)
    );
  end else begin : g_bypass
    assign tick_50hz = ref_tick;
  end

  tod_div_pair #(.LO_MOD(FRAC_LO), .HI_MOD(FRAC_HI)) u_frac (
    .clk(clk), .rst_n(rst_n), .en_i(tick_50hz), .tick_o(tick_sec),
    .lo_o(frac_lo), .hi_o(frac_hi)
  );
  assign frac_unused = ^{frac_lo, frac_hi};

  tod_div_pair #(.LO_MOD(SEC_LO), .HI_MOD(SEC_HI)) u_sec (
    .clk(clk), .rst_n(rst_n), .en_i(tick_sec), .tick_o(tick_min),
    .lo_o(sec_lo), .hi_o(sec_hi)
  );

  tod_div_pair #(.LO_MOD(MIN_LO), .HI_MOD(MIN_HI)) u_min (
    .clk(clk), .rst_n(rst_n), .en_i(tick_min), .tick_o(tick_hour),
    .lo_o(min_lo), .hi_o(min_hi)
  );

  tod_div_pair #(.LO_MOD(HOUR_LO), .HI_MOD(HOUR_HI)) u_hour (
    .clk(clk), .rst_n(rst_n), .en_i(tick_hour), .tick_o(tick_day),
    .lo_o(hour_lo), .hi_o(hour_hi)
  );

  // R4..R7: each strobe only with the one below it
  a_r4_sec_chain: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sec |-> tick_50hz);
  a_r5_min_chain: assert property (@(posedge clk) disable iff (!rst_n)
    tick_min |-> tick_sec);
  a_r6_hour_chain: assert property (@(posedge clk) disable iff (!rst_n)
    tick_hour |-> tick_min);
  a_r7_day_chain: assert property (@(posedge clk) disable iff (!rst_n)
    tick_day |-> tick_hour);
  // R8: no reference strobe, no 50 Hz strobe
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |-> !tick_50hz);

endmodule

// File: tb/tb_tod_divider_chain.sv
module tb_tod_divider_chain;
  localparam int CLK_PERIOD = 10;
  localparam int P_FRAC = 6;      // 2*3
  localparam int P_MIN  = 72;     // *12
  localparam int P_HOUR = 432;    // *6
  localparam int P_DAY  = 10368;  // *24
  localparam int P_PRE  = 10000;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0;
  logic t50, tsec, tmin, thour, tday;
  logic [3:0] slo, shi, mlo, mhi, hlo, hhi;
  logic p50, psec, pmin, phour, pday;
  logic [3:0] pslo, pshi, pmlo, pmhi, phlo, phhi;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_divider_chain #(
    .PRESCALE_EN(1'b0), .FRAC_LO(2), .FRAC_HI(3), .SEC_LO(6), .SEC_HI(2),
    .MIN_LO(3), .MIN_HI(2), .HOUR_LO(6), .HOUR_HI(4)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .tick_50hz(t50), .tick_sec(tsec), .tick_min(tmin), .tick_hour(thour),
    .tick_day(tday), .sec_lo(slo), .sec_hi(shi), .min_lo(mlo), .min_hi(mhi),
    .hour_lo(hlo), .hour_hi(hhi)
  );

  tod_divider_chain dut_pre (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .tick_50hz(p50), .tick_sec(psec), .tick_min(pmin), .tick_hour(phour),
    .tick_day(pday), .sec_lo(pslo), .sec_hi(pshi), .min_lo(pmlo),
    .min_hi(pmhi), .hour_lo(phlo), .hour_hi(phhi)
  );

  typedef struct {
    logic       t, s50, ssec, smin, shour, sday, spre;
    logic [3:0] slo, shi, mlo, mhi, hlo, hhi;
  } exp_t;

  exp_t q[$];
  int n_ticks = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: one cycle, pushes what the requirements predict
  task automatic drive(input logic t);
    exp_t e;
    int m, s, mn, h;
    @(negedge clk);
    ref_tick = t;
    #1;
    e.t     = t;
    e.s50   = t;
    e.ssec  = t && ((n_ticks + 1) % P_FRAC == 0);
    e.smin  = t && ((n_ticks + 1) % P_MIN  == 0);
    e.shour = t && ((n_ticks + 1) % P_HOUR == 0);
    e.sday  = t && ((n_ticks + 1) % P_DAY  == 0);
    e.spre  = t && ((n_ticks + 1) % P_PRE  == 0);
    m  = n_ticks + (t ? 1 : 0);
    s  = m / P_FRAC;
    mn = s / 12;
    h  = mn / 6;
    e.slo = 4'(s % 6);   e.shi = 4'((s / 6) % 2);
    e.mlo = 4'(mn % 3);  e.mhi = 4'((mn / 3) % 2);
    e.hlo = 4'(h % 6);   e.hhi = 4'((h / 6) % 4);
    q.push_back(e);
    n_ticks = m;
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        if (e.t) chk("R3", "tick_50hz bypass", int'(t50), int'(e.s50));
        else     chk("R8", "tick_50hz idle", int'(t50), 0);
        chk("R4",  "tick_sec", int'(tsec), int'(e.ssec));
        chk("R5",  "tick_min", int'(tmin), int'(e.smin));
        chk("R6",  "tick_hour", int'(thour), int'(e.shour));
        chk("R7",  "tick_day", int'(tday), int'(e.sday));
        chk("R2",  "prescaled tick_50hz", int'(p50), int'(e.spre));
        @(posedge clk);
        #2;
        chk("R5",  "sec_lo (R9 wrap)", int'(slo), int'(e.slo));
        chk("R5",  "sec_hi", int'(shi), int'(e.shi));
        chk("R6",  "min_lo", int'(mlo), int'(e.mlo));
        chk("R6",  "min_hi", int'(mhi), int'(e.mhi));
        chk("R7",  "hour_lo", int'(hlo), int'(e.hlo));
        chk("R10", "hour_hi", int'(hhi), int'(e.hhi));
      end
    end
  end

  task automatic check_reset_state();
    chk("R1", "sec_lo", int'(slo), 0);  chk("R1", "sec_hi", int'(shi), 0);
    chk("R1", "min_lo", int'(mlo), 0);  chk("R1", "min_hi", int'(mhi), 0);
    chk("R1", "hour_lo", int'(hlo), 0); chk("R1", "hour_hi", int'(hhi), 0);
    chk("R1", "strobes", int'({t50, tsec, tmin, thour, tday, p50}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 2);
    check_reset_state();
    @(negedge clk); rst_n = 1'b1;
    // back-to-back strobes: first day
    for (int i = 0; i < P_DAY; i++) drive(1'b1);
    // gapped strobes through the second day and past the 2nd prescale tick
    for (int i = 0; n_ticks < 2 * P_DAY + 10; i++) drive((i % 7) != 3);
    for (int i = 0; i < 5; i++) drive(1'b0);
    repeat (4) @(negedge clk);
    // reset mid-count
    rst_n = 1'b0;
    #2;
    check_reset_state();
    @(negedge clk); rst_n = 1'b1;
    n_ticks = 0;
    for (int i = 0; i < 20; i++) drive(1'b1);
    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule